// File: doc/BRIEF.md
# Binary to decimal ASCII line formatter

This block turns a 12-bit unsigned sample into one line of text for a serial console. Each accepted sample becomes six bytes: four zero-padded decimal digits, most significant first, then a carriage return and a line feed. The bytes leave through a valid/ready byte stream, so the block can feed a slow serial transmitter directly.

A sample is offered with a one-cycle `smp_valid` strobe. The block takes it only when it is idle. It converts the value to decimal over several cycles by repeated subtraction of 1000, 100, 10 and 1, and only then offers the first byte. `busy` stays high from the cycle after acceptance until the line feed has been taken. Samples that arrive while `busy` is high are dropped.

Back-pressure rules for the output stream:
- A byte is transferred on a rising edge where `out_valid` and `out_ready` are both high.
- Once `out_valid` rises, it stays high and `out_data` stays unchanged until that transfer.
- `out_valid` never depends combinationally on `out_ready`.
- The sink may hold `out_ready` low for any number of cycles.

Top module: `dec_line_fmt`

## Requirements
- R1: Every accepted sample produces exactly six output bytes: four digit characters, then 0x0D, then 0x0A.
- R2: Digit characters are 0x30 plus the decimal digit, sent thousands first, with leading zeros kept (7 gives "0007").
- R3: The full input range is formatted correctly, from 0 ("0000") to 4095 ("4095").
- R4: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` is still high and `out_data` is unchanged.
- R5: A sample is accepted when `smp_valid` is high and `busy` is low, and `busy` is high on the following cycle.
- R6: A sample presented while `busy` is high is dropped and produces no output bytes.
- R7: `busy` goes low in the cycle after the line feed byte is transferred.
- R8: Reset clears `out_valid` and `busy` and discards any partly sent line.
- R9: `out_valid` is only high while `busy` is high, and the first byte is not offered in the cycle right after acceptance because conversion takes at least one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned sample value |
| busy | output | 1 | High while a line is being converted or sent |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink ready for output byte |
| out_data | output | 8 | Output ASCII byte |

## Verification
The assertions assume that the sink never needs `out_valid` to wait on `out_ready`. They also assume that `smp_data` stays within 12 bits, which the port width guarantees.

The stimulus drives `out_ready` in three patterns: always high, pseudo-random, and mostly low. This exercises long stalls while keeping the hold rule observable. Samples are normally issued only when `busy` is low. One deliberate strobe is placed during a busy line so that the drop rule can be seen at the output stream. A reset is also applied in the middle of a line, and the partly sent line is discarded from the expected queue.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam logic [7:0] CHAR_ZERO = 8'h30;
  localparam logic [7:0] CHAR_CR   = 8'h0D;
  localparam logic [7:0] CHAR_LF   = 8'h0A;

  function automatic int unsigned pow10(input int n);
    int unsigned r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/dlf_bcd_conv.sv
module dlf_bcd_conv
  import dlf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NDIG   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DATA_W-1:0]   value,
  output logic                done,
  output logic [NDIG*4-1:0]   digits
);
  localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic              running;
  logic [DATA_W-1:0] rem;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        cnt;
  logic [31:0]       weight;
  logic              take;

  // weight of the digit currently being extracted
  always_comb begin
    weight = pow10(NDIG - 1 - int'(idx));
    take   = 32'(rem) >= weight;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      rem     <= '0;
      idx     <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      digits  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        rem     <= value;
        idx     <= '0;
        cnt     <= '0;
      end else if (running) begin
        if (take) begin
          rem <= rem - DATA_W'(weight);
          cnt <= cnt + 4'd1;
        end else begin
          digits[(NDIG-1-int'(idx))*4 +: 4] <= cnt;
          cnt <= '0;
          if (idx == IDX_W'(NDIG-1)) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dlf_line_ser.sv
module dlf_line_ser
  import dlf_pkg::*;
#(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NDIG*4-1:0] digits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              line_done
);
  localparam int LINE_LEN = NDIG + 2;
  localparam int IDX_W    = $clog2(LINE_LEN);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [NDIG*4-1:0] dig_q;
  logic [7:0]        line_b [LINE_LEN];

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign line_b[g] = CHAR_ZERO + {4'b0000, dig_q[(NDIG-1-g)*4 +: 4]};
  end
  assign line_b[NDIG]   = CHAR_CR;
  assign line_b[NDIG+1] = CHAR_LF;

  always_comb begin
    out_valid = active;
    out_data  = (int'(idx) < LINE_LEN) ? line_b[idx] : CHAR_LF;
    line_done = active && out_ready && (idx == IDX_W'(LINE_LEN-1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      dig_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      dig_q  <= digits;
    end else if (active && out_ready) begin
      if (idx == IDX_W'(LINE_LEN-1)) active <= 1'b0;
      else                           idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/dec_line_fmt.sv
module dec_line_fmt
  import dlf_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NDIG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  logic              accept;
  logic              conv_done;
  logic [NDIG*4-1:0] digits;
  logic              line_done;

  assign accept = smp_valid && !busy;

  dlf_bcd_conv #(.DATA_W(DATA_W), .NDIG(NDIG)) conv_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .value  (smp_data),
    .done   (conv_done),
    .digits (digits)
  );

  dlf_line_ser #(.NDIG(NDIG)) ser_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (conv_done),
    .digits    (digits),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .line_done (line_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         busy <= 1'b0;
    else if (accept)    busy <= 1'b1;
    else if (line_done) busy <= 1'b0;
  end
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4
  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !busy |=> busy && !out_valid); // R5
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_data == 8'h0A |=> !busy); // R7
  AST_CHAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == 8'h0D || out_data == 8'h0A ||
                   (out_data >= 8'h30 && out_data <= 8'h39))); // R2
  AST_QUIET_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !out_valid); // R8
  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !$isunknown(smp_data)); // R3
endmodule

bind dec_line_fmt dlf_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/dec_line_fmt_tb_top.sv
module dec_line_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        busy;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q[$];
  bit   stall_prev = 0;
  logic [7:0] data_prev = '0;
  bit   lf_pending = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  dec_line_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor and ready driver: scoreboard side
  always @(negedge clk) begin
    if (!rst_n) begin
      stall_prev = 0;
      lf_pending = 0;
    end else begin
      if (lf_pending) begin
        check(busy == 1'b0, "R7 busy low after line feed", busy, 0);
        lf_pending = 0;
      end
      if (stall_prev) begin
        check(out_valid == 1'b1 && out_data == data_prev, "R4 hold under stall",
              {out_valid, out_data}, {1'b1, data_prev});
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0];
        default: out_ready = (lfsr[2:0] == 3'b000);
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected byte", out_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R1 R2 byte compare", out_data, e);
          if (e == 8'h0A) lf_pending = 1;
        end
      end
      stall_prev = out_valid && !out_ready;
      data_prev  = out_data;
    end
  end

  task automatic send_line(input int v);
    while (busy) @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 12'(v);
    exp_q.push_back(8'h30 + 8'((v / 1000) % 10));
    exp_q.push_back(8'h30 + 8'((v / 100) % 10));
    exp_q.push_back(8'h30 + 8'((v / 10) % 10));
    exp_q.push_back(8'h30 + 8'(v % 10));
    exp_q.push_back(8'h0D);
    exp_q.push_back(8'h0A);
    @(negedge clk);
    smp_valid = 1'b0;
    check(busy == 1'b1, "R5 busy after accept", busy, 1);
    check(out_valid == 1'b0, "R9 no byte before conversion", out_valid, 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R8 reset state", {busy, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    ready_mode = 0;
    send_line(0);    drain(); // R3 lower bound
    send_line(4095); drain(); // R3 upper bound
    send_line(7);    drain(); // R2 zero padding
    send_line(1000); send_line(999); send_line(10); send_line(9);
    drain();

    ready_mode = 1;
    for (int i = 0; i < 20; i++) send_line((i * 613 + 41) % 4096);
    drain();

    ready_mode = 2;
    send_line(1234); send_line(3000); send_line(4095);
    drain();

    // R6: strobe while busy is dropped
    ready_mode = 2;
    send_line(123);
    repeat (2) @(negedge clk);
    check(busy == 1'b1, "R6 still busy before stray strobe", busy, 1);
    smp_valid = 1'b1;
    smp_data  = 12'd999;
    @(negedge clk);
    smp_valid = 1'b0;
    drain();
    repeat (60) @(negedge clk);
    check(busy == 1'b0 && exp_q.size() == 0, "R6 stray sample dropped", busy, 0);

    // R8: reset in the middle of a line
    ready_mode = 2;
    send_line(2048);
    while (!out_valid) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R8 mid-line reset", {busy, out_valid}, 0);
    exp_q.delete();
    rst_n = 1'b1;
    @(negedge clk);
    ready_mode = 1;
    send_line(321); drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule